// File: doc/BRIEF.md
# Scan-Testable Two-Requester Call Element

This block shares one downstream service between several requesters that signal with transitions rather than levels. Each requester announces a call by toggling its request line; the block merges every request toggle onto one shared request output through an exclusive-OR. When the service answers by toggling the shared completion input, the answer is steered back only to the requester whose call is outstanding, as a toggle on that requester's own done line. Rising and falling edges carry the same meaning throughout.

The per-requester state bit that remembers whether a call has been answered sits in a state-holding cell that also acts as one stage of a serial scan chain. With the scan mode input raised, the functional inputs of every cell are frozen, and each rising edge of the scan clock moves the chain by one place. The link between adjacent cells inverts, so test software can load any call state, resume normal operation from it, and later shift the state out for comparison. The block is modelled synchronously: the completion input and the scan clock are sampled on the system clock, and their edges are found by comparing with the previous sample. Arbitration of simultaneous calls is left to the requesters.

Top module: `call_scan_unit`

## Requirements
- R1: After reset every done output, the shared request output and the serial output are 0.
- R2: The shared request output is the exclusive-OR of all request inputs, so any single request toggle toggles it in the same cycle.
- R3: With scan mode low, a requester is primed when its request input differs from its done output; on a clock edge at which the completion input differs from its value at the previous edge, every primed requester's done output toggles.
- R4: With scan mode low, an unprimed requester's done output is unchanged by a completion toggle, and no done output changes in a cycle without a completion toggle.
- R5: A falling completion transition answers a primed requester exactly as a rising one does.
- R6: With scan mode high, request and completion changes have no effect on the done outputs; a completion toggle seen while scan mode is high is consumed and is not answered later.
- R7: A shift happens on a clock edge at which scan mode is high and the scan clock is high after being low at the previous edge; it loads the serial input into the state of requester 0 and the inverse of requester k-1's state into requester k. The serial output shows the state of the last requester.
- R8: With two requesters, shifting in 0 and then 1 leaves both done outputs at 1.
- R9: A rising scan clock with scan mode low has no effect, and a scan clock held high shifts only once.
- R10: When scan mode returns low, priming and answering resume from the loaded state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_CALLERS | Per-requester request, one toggle per call |
| call_req_o | output | 1 | Shared request toward the service |
| done_i | input | 1 | Shared completion from the service, one toggle per answer |
| done_o | output | N_CALLERS | Per-requester done, equal to each cell's state |
| scan_mode_i | input | 1 | Scan mode; high freezes the functional path |
| scan_clk_i | input | 1 | Scan clock; a rising level in scan mode shifts once |
| scan_in_i | input | 1 | Serial input to requester 0 |
| scan_out_o | output | 1 | Serial output, state of the last requester |

## Verification
The bench builds the block with its defaults, two requesters and inverting links, which is the configuration where the 0-then-1 load must yield both cells set and where a two-pulse readout exposes each link's inversion. With only two cells, every combination of primed and unprimed requesters is reached quickly by random request toggles, including both being primed at once so that one completion answers both. Random switches between scan mode and normal mode reach completion toggles that arrive while frozen and scan clock edges that arrive outside scan mode.

// File: rtl/call_scan_pkg.sv
package call_scan_pkg;

   typedef enum logic [1:0] {
      CELL_HOLD   = 2'd0,
      CELL_ANSWER = 2'd1,
      CELL_SHIFT  = 2'd2
   } cell_op_e;

   localparam int unsigned MAX_CALLERS = 16;

   function automatic cell_op_e pick_op(input logic scan_mode,
                                        input logic shift,
                                        input logic done_evt,
                                        input logic primed);
      cell_op_e op;
      op = CELL_HOLD;
      if (scan_mode) begin
         if (shift) op = CELL_SHIFT;
      end else if (done_evt && primed) begin
         op = CELL_ANSWER;
      end
      return op;
   endfunction

endpackage

// File: rtl/call_scan_edge.sv
module call_scan_edge #(
   parameter bit RISE_ONLY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic evt_o
);
   logic sig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q <= 1'b0;
      else        sig_q <= sig_i;
   end

   generate
      if (RISE_ONLY) begin : g_rise
         assign evt_o = sig_i & ~sig_q;
      end else begin : g_any
         assign evt_o = sig_i ^ sig_q;
      end
   endgenerate
endmodule

// File: rtl/call_scan_merge.sv
module call_scan_merge #(
   parameter int unsigned WIDTH = 2
) (
   input  logic [WIDTH-1:0] req_i,
   output logic             merged_o
);
   logic [WIDTH:0] acc;

   assign acc[0] = 1'b0;
   generate
      for (genvar k = 0; k < WIDTH; k++) begin : g_fold
         assign acc[k+1] = acc[k] ^ req_i[k];
      end
   endgenerate
   assign merged_o = acc[WIDTH];
endmodule

// File: rtl/call_scan_cell.sv
module call_scan_cell
   import call_scan_pkg::*;
#(
   parameter bit LINK_INVERT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic done_evt_i,
   input  logic scan_mode_i,
   input  logic shift_i,
   input  logic link_i,
   output logic state_o,
   output logic link_o
);
   logic     state_q;
   cell_op_e op;

   always_comb op = pick_op(scan_mode_i, shift_i, done_evt_i, req_i ^ state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= 1'b0;
      end else begin
         unique case (op)
            CELL_ANSWER: state_q <= ~state_q;
            CELL_SHIFT:  state_q <= link_i;
            default:     state_q <= state_q;
         endcase
      end
   end

   assign state_o = state_q;

   generate
      if (LINK_INVERT) begin : g_inv
         assign link_o = ~state_q;
      end else begin : g_pass
         assign link_o = state_q;
      end
   endgenerate
endmodule

// File: rtl/call_scan_unit.sv
module call_scan_unit #(
   parameter int unsigned N_CALLERS   = 2,
   parameter bit          LINK_INVERT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_CALLERS-1:0] req_i,
   output logic                 call_req_o,
   input  logic                 done_i,
   output logic [N_CALLERS-1:0] done_o,
   input  logic                 scan_mode_i,
   input  logic                 scan_clk_i,
   input  logic                 scan_in_i,
   output logic                 scan_out_o
);
   import call_scan_pkg::*;

   localparam int unsigned LINKS = N_CALLERS + 1;

   generate
      if (N_CALLERS < 2) begin : g_chk_min
         $error("call_scan_unit: N_CALLERS must be at least 2");
      end
      if (N_CALLERS > MAX_CALLERS) begin : g_chk_max
         $error("call_scan_unit: N_CALLERS exceeds MAX_CALLERS");
      end
   endgenerate

   logic             done_evt;
   logic             sclk_rise;
   logic             shift;
   logic [LINKS-1:0] link;

   call_scan_merge #(.WIDTH(N_CALLERS)) u_merge (
      .req_i    (req_i),
      .merged_o (call_req_o)
   );

   call_scan_edge #(.RISE_ONLY(1'b0)) u_done_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sig_i (done_i),
      .evt_o (done_evt)
   );

   call_scan_edge #(.RISE_ONLY(1'b1)) u_sclk_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sig_i (scan_clk_i),
      .evt_o (sclk_rise)
   );

   assign shift   = scan_mode_i & sclk_rise;
   assign link[0] = scan_in_i;

   generate
      for (genvar k = 0; k < N_CALLERS; k++) begin : g_cell
         call_scan_cell #(.LINK_INVERT(LINK_INVERT)) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_i       (req_i[k]),
            .done_evt_i  (done_evt),
            .scan_mode_i (scan_mode_i),
            .shift_i     (shift),
            .link_i      (link[k]),
            .state_o     (done_o[k]),
            .link_o      (link[k+1])
         );
      end
   endgenerate

   assign scan_out_o = LINK_INVERT ? ~link[LINKS-1] : link[LINKS-1];
endmodule

// File: rtl/call_scan_chk.sv
module call_scan_chk #(
   parameter int unsigned N_CALLERS   = 2,
   parameter bit          LINK_INVERT = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N_CALLERS-1:0] req_i,
   input logic                 call_req_o,
   input logic                 done_i,
   input logic [N_CALLERS-1:0] done_o,
   input logic                 scan_mode_i,
   input logic                 scan_clk_i,
   input logic                 scan_in_i,
   input logic                 scan_out_o
);
   logic                 prev_done;
   logic                 prev_sclk;
   logic                 prev_call;
   logic [N_CALLERS-1:0] prev_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_done <= 1'b0;
         prev_sclk <= 1'b0;
         prev_call <= 1'b0;
         prev_req  <= '0;
      end else begin
         prev_done <= done_i;
         prev_sclk <= scan_clk_i;
         prev_call <= call_req_o;
         prev_req  <= req_i;
      end
   end

   wire d_evt  = done_i ^ prev_done;
   wire do_sh  = scan_mode_i & scan_clk_i & ~prev_sclk;

   p_merge_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(req_i ^ prev_req) == 1) |-> (call_req_o != prev_call));

   p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_mode_i && !d_evt) |=> $stable(done_o));

   p_scan_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_mode_i && !do_sh) |=> $stable(done_o));

   p_shift_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
      do_sh |=> (done_o[0] == $past(scan_in_i)));

   p_sout_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
      do_sh |=> (scan_out_o == ($past(done_o[N_CALLERS-2]) ^ LINK_INVERT)));

   p_no_shift_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_mode_i && !d_evt && scan_clk_i && !prev_sclk) |=> $stable(done_o));

   generate
      for (genvar k = 0; k < N_CALLERS; k++) begin : g_per
         p_primed_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!scan_mode_i && d_evt && (req_i[k] != done_o[k])) |=> (done_o[k] != $past(done_o[k])));
         p_unprimed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!scan_mode_i && (req_i[k] == done_o[k])) |=> (done_o[k] == $past(done_o[k])));
      end
   endgenerate
endmodule

bind call_scan_unit call_scan_chk #(.N_CALLERS(N_CALLERS), .LINK_INVERT(LINK_INVERT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_i       (req_i),
   .call_req_o  (call_req_o),
   .done_i      (done_i),
   .done_o      (done_o),
   .scan_mode_i (scan_mode_i),
   .scan_clk_i  (scan_clk_i),
   .scan_in_i   (scan_in_i),
   .scan_out_o  (scan_out_o)
);

// File: tb/sim_call_scan_unit.sv
module sim_call_scan_unit;
   localparam int N = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic         done = 1'b0;
   logic         mode = 1'b0;
   logic         sclk = 1'b0;
   logic         sin = 1'b0;
   logic         call_req;
   logic [N-1:0] done_o;
   logic         sout;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic [N-1:0] m_c;
   logic         m_dq;
   logic         m_sq;

   always #10 clk = ~clk;

   call_scan_unit #(.N_CALLERS(N), .LINK_INVERT(1'b1)) u0 (
      .clk (clk), .rst_n (rst_n), .req_i (req), .call_req_o (call_req),
      .done_i (done), .done_o (done_o), .scan_mode_i (mode),
      .scan_clk_i (sclk), .scan_in_i (sin), .scan_out_o (sout)
   );

   function automatic logic [N-1:0] next_state(input logic [N-1:0] c, input logic [N-1:0] r,
                                               input logic d, input logic dq,
                                               input logic md, input logic sc,
                                               input logic sq, input logic si);
      logic [N-1:0] n;
      n = c;
      if (md) begin
         if (sc && !sq) begin
            n[0] = si;
            for (int k = 1; k < N; k++) n[k] = ~c[k-1];
         end
      end else if (d != dq) begin
         for (int k = 0; k < N; k++) if (r[k] != c[k]) n[k] = ~c[k];
      end
      return n;
   endfunction

   function automatic logic [N+1:0] pack_exp(input logic [N-1:0] c, input logic [N-1:0] r);
      return {c[N-1], ^r, c};
   endfunction

   task automatic check(input string tag, input logic [N+1:0] act, input logic [N+1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b (sout,call,done)", tag, act, exp);
      end
   endtask

   task automatic step(input string tag, input logic [N-1:0] r, input logic d,
                       input logic md, input logic sc, input logic si);
      @(negedge clk);
      req = r; done = d; mode = md; sclk = sc; sin = si;
      m_c  = next_state(m_c, r, d, m_dq, md, sc, m_sq, si);
      m_dq = d;
      m_sq = sc;
      @(negedge clk);
      check(tag, {sout, call_req, done_o}, pack_exp(m_c, r));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [N-1:0] r;
      logic d, md, sc, si;
      m_c = '0; m_dq = 1'b0; m_sq = 1'b0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check("R1 reset", {sout, call_req, done_o}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {sout, call_req, done_o}, '0);

      // R2 / R3: caller 0 then caller 1
      step("R2 req0 rise", 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
      step("R3 answer caller0", 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
      step("R2 req1 rise", 2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
      step("R5 falling answer caller1", 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
      // R4: nobody primed, completion toggle ignored
      step("R4 unprimed toggle", 2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
      step("R4 quiet", 2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
      // R9: scan clock outside scan mode
      step("R9 sclk no mode", 2'b11, 1'b1, 1'b0, 1'b1, 1'b1);
      step("R9 sclk low", 2'b11, 1'b1, 1'b0, 1'b0, 1'b1);
      // R6: freeze, functional toggles ignored
      step("R6 enter scan", 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
      step("R6 done lost", 2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
      // R7/R8: load 0 then 1
      step("R7 shift0", 2'b10, 1'b0, 1'b1, 1'b1, 1'b0);
      step("R9 held high", 2'b10, 1'b0, 1'b1, 1'b1, 1'b1);
      step("R7 sclk low", 2'b10, 1'b0, 1'b1, 1'b0, 1'b1);
      step("R8 shift1", 2'b10, 1'b0, 1'b1, 1'b1, 1'b1);
      if (done_o !== 2'b11) begin
         checks++; fails++;
         $display("FAIL R8 actual=%b expected=11", done_o);
      end else checks++;
      // R10: resume from loaded state (11), caller0 request low -> primed
      step("R10 resume", 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
      step("R10 answer loaded", 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
      // R7 readout
      step("R7 read enter", 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
      step("R7 read pulse", 2'b10, 1'b1, 1'b1, 1'b1, 1'b0);
      step("R7 read low", 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
      step("R10 exit", 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);

      r = req; d = done; md = 1'b0; sc = 1'b0; si = 1'b0;
      for (int it = 0; it < 600; it++) begin
         int unsigned x;
         x = $urandom;
         if (x[3:0] == 4'd0) md = ~md;
         if (x[6:4] < 3'd3) r[x[7]] = ~r[x[7]];
         if (x[9:8] == 2'd0) d = ~d;
         sc = x[10];
         si = x[11];
         step(md ? "R7 random scan" : "R3 random func", r, d, md, sc, si);
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule